// File: doc/BRIEF.md
# Pipelined DES Block Cipher Engine

This block encrypts or decrypts 64-bit blocks with the Data Encryption Standard at a rate of one block per clock. The sixteen Feistel rounds are unrolled into sixteen register stages. Each block enters with its own 64-bit key and its own direction bit. Key, direction and valid travel down the pipeline with the data, so consecutive blocks can use different keys and modes with no flush and no gap.

The entry logic applies the initial permutation to the block and permuted choice 1 to the key. It also pre-rotates the C/D key halves for the first round. Each of stages 1 to 15 selects its round key with permuted choice 2 and computes one round. It then rotates its own C/D pair for the next round: left when encrypting, right when decrypting. Stage 16 receives its C/D pair ready for use and holds no key state. It computes the last round, swaps the halves and applies the inverse initial permutation into the output register.

Both ends are valid/ready streams. Back-pressure works as a single pipeline-wide enable. When the output register holds a block that the sink does not take, every stage freezes and the input refuses new blocks. When the output register is empty or is being read, every stage advances and the input accepts a block.

Top module: `des_pipe`

## Requirements
- R1: With encrypt mode (in_decrypt = 0), the block comes out as the DES ciphertext of in_data under in_key. DES bit 1 is bit 63 of each 64-bit bus, so key 133457799BBCDFF1 with plaintext 0123456789ABCDEF gives 85E813540F0AB405.
- R2: With decrypt mode (in_decrypt = 1), the block comes out as the DES plaintext of in_data under in_key, so ciphertext 85E813540F0AB405 with key 133457799BBCDFF1 gives 0123456789ABCDEF.
- R3: While out_ready stays high, a block accepted on a rising edge appears with out_valid high right after the 16th rising edge, counting the accepting edge as the first.
- R4: Blocks accepted on consecutive edges come out on consecutive edges, in order. Each block uses its own key and mode, even when these differ from one block to the next.
- R5: Cycles with no accepted block reach the output as cycles with out_valid low. The spacing between blocks is kept, and no output appears without a matching accepted block.
- R6: While out_valid is high and out_ready is low, out_valid, out_data and out_decrypt hold their values into the next cycle. No block is lost or duplicated.
- R7: in_ready is high whenever out_valid is low or out_ready is high. It is low while out_valid is high and out_ready is low.
- R8: A synchronous active-high rst clears the valid flag of every stage. After rst, out_valid stays low until a block accepted after the reset has passed through, and blocks in flight at the reset never appear.
- R9: The least significant bit of each key byte (bits 0, 8, ..., 56 of in_key) has no effect on the result.
- R10: out_decrypt presents the mode bit that was given with the block now shown on out_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all valid flags |
| in_valid | input | 1 | A block, key and mode are offered |
| in_ready | output | 1 | The offered block is taken on this edge |
| in_data | input | 64 | Plaintext or ciphertext block, DES bit 1 at bit 63 |
| in_key | input | 64 | Key, DES bit 1 at bit 63, byte LSBs ignored |
| in_decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The sink takes the result on this edge |
| out_data | output | 64 | Result block |
| out_decrypt | output | 1 | Mode the result was produced with |

## Verification
The bench uses four published key/plaintext/ciphertext triples in both directions. A design with a bit-order error, a wrong table entry, or a key rotation running the wrong way or by the wrong amount in any round gives a wrong value for at least one of them. A long run switches mode and key on every block, which exposes a stage that reads the mode or key of a neighbouring block instead of its own. Gapped traffic exposes a valid bit that is dropped or duplicated. A random out_ready pattern exposes stages that move while the output is stalled, which shows up as lost, repeated or changing results. The bench also checks that flipped key parity bits have no effect, and that a reset in mid-flight leaves no stale block to appear later.

// File: rtl/des_pkg.sv
package des_pkg;

  localparam int BLK_W   = 64;
  localparam int HALF_W  = BLK_W / 2;
  localparam int CD_W    = 56;
  localparam int CD_HALF = CD_W / 2;
  localparam int SUB_W   = 48;
  localparam int ROUNDS  = 16;
  localparam int SBOX_N  = 8;
  localparam int SBOX_IN = SUB_W / SBOX_N;
  localparam int SBOX_OUT = HALF_W / SBOX_N;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [CD_W-1:0]   cd_t;
  typedef logic [SUB_W-1:0]  subkey_t;
  typedef logic [BLK_W-1:0]  blk_t;

  // Key choice 1: source bit (1 = MSB) for each of the 56 C/D bits.
  localparam int KC1_SRC [56] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  // Key choice 2: source bit of C/D for each of the 48 round-key bits.
  localparam int KC2_SRC [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // Bit mix applied to the 32 substitution outputs.
  localparam int MIX_SRC [32] = '{
    16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
     2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

  // Substitution tables, 64 nibbles each, row-major (row = outer bits).
  localparam logic [255:0] SUB_TAB [SBOX_N] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  // Source bit of the entry permutation for output position i (0-based).
  function automatic int entry_src(int i);
    int row;
    int col;
    row = i / 8;
    col = i % 8;
    return ((row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4))) - 8 * col;
  endfunction

  function automatic blk_t entry_perm(blk_t x);
    blk_t y;
    for (int i = 0; i < BLK_W; i++)
      y[6'(63 - i)] = x[6'(64 - entry_src(i))];
    return y;
  endfunction

  function automatic blk_t exit_perm(blk_t x);
    blk_t y;
    for (int i = 0; i < BLK_W; i++)
      y[6'(64 - entry_src(i))] = x[6'(63 - i)];
    return y;
  endfunction

  function automatic cd_t key_choice1(blk_t k);
    cd_t y;
    for (int i = 0; i < CD_W; i++)
      y[6'(55 - i)] = k[6'(64 - KC1_SRC[i])];
    return y;
  endfunction

  function automatic subkey_t key_choice2(cd_t cd);
    subkey_t y;
    for (int i = 0; i < SUB_W; i++)
      y[6'(47 - i)] = cd[6'(56 - KC2_SRC[i])];
    return y;
  endfunction

  function automatic subkey_t expand_half(half_t r);
    subkey_t y;
    int src;
    for (int i = 0; i < SUB_W; i++) begin
      src = ((4 * (i / 6) + (i % 6) - 1 + HALF_W) % HALF_W) + 1;
      y[6'(47 - i)] = r[5'(32 - src)];
    end
    return y;
  endfunction

  function automatic half_t mix_half(half_t s);
    half_t y;
    for (int i = 0; i < HALF_W; i++)
      y[5'(31 - i)] = s[5'(32 - MIX_SRC[i])];
    return y;
  endfunction

  function automatic logic [3:0] sub_lookup(int box, logic [5:0] a);
    logic [5:0] idx;
    idx = {a[5], a[0], a[4:1]};
    return SUB_TAB[3'(box)][8'(255 - 4 * int'(idx)) -: 4];
  endfunction

  // Rotation applied to C and D before the given round (1-based).
  function automatic int rot_amount(int round, logic dec);
    logic single;
    single = (round == 2) || (round == 9) || (round == 16);
    if (dec)
      return (round == 1) ? 0 : (single ? 1 : 2);
    return (single || round == 1) ? 1 : 2;
  endfunction

  function automatic cd_t cd_rotate(cd_t cd, int amt, logic dec);
    logic [CD_HALF-1:0] c;
    logic [CD_HALF-1:0] d;
    c = cd[CD_W-1:CD_HALF];
    d = cd[CD_HALF-1:0];
    for (int k = 0; k < 2; k++) begin
      if (k < amt) begin
        if (dec) begin
          c = {c[0], c[CD_HALF-1:1]};
          d = {d[0], d[CD_HALF-1:1]};
        end else begin
          c = {c[CD_HALF-2:0], c[CD_HALF-1]};
          d = {d[CD_HALF-2:0], d[CD_HALF-1]};
        end
      end
    end
    return {c, d};
  endfunction

endpackage

// File: rtl/des_sbox_bank.sv
module des_sbox_bank
  import des_pkg::*;
(
  input  subkey_t sel_in,
  output half_t   sub_out
);
  for (genvar g = 0; g < SBOX_N; g++) begin : g_box
    assign sub_out[HALF_W-1-SBOX_OUT*g -: SBOX_OUT] =
      sub_lookup(g, sel_in[SUB_W-1-SBOX_IN*g -: SBOX_IN]);
  end
endmodule

// File: rtl/des_round.sv
module des_round
  import des_pkg::*;
(
  input  half_t   l_in,
  input  half_t   r_in,
  input  subkey_t rkey,
  output half_t   l_out,
  output half_t   r_out
);
  subkey_t mixed_in;
  half_t   sub_res;

  assign mixed_in = expand_half(r_in) ^ rkey;

  des_sbox_bank u_sbox (
    .sel_in (mixed_in),
    .sub_out(sub_res)
  );

  assign l_out = r_in;
  assign r_out = l_in ^ mix_half(sub_res);
endmodule

// File: rtl/des_stage.sv
module des_stage
  import des_pkg::*;
#(
  parameter int ROUND = 1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  v_in,
  input  logic  dec_in,
  input  half_t l_in,
  input  half_t r_in,
  input  cd_t   cd_in,
  output logic  v_out,
  output logic  dec_out,
  output half_t l_out,
  output half_t r_out,
  output cd_t   cd_out
);
  half_t l_nx;
  half_t r_nx;

  des_round u_round (
    .l_in (l_in),
    .r_in (r_in),
    .rkey (key_choice2(cd_in)),
    .l_out(l_nx),
    .r_out(r_nx)
  );

  always_ff @(posedge clk) begin
    if (rst)
      v_out <= 1'b0;
    else if (adv)
      v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      dec_out <= dec_in;
      l_out   <= l_nx;
      r_out   <= r_nx;
      cd_out  <= cd_rotate(cd_in, rot_amount(ROUND + 1, dec_in), dec_in);
    end
  end
endmodule

// File: rtl/des_last_stage.sv
module des_last_stage
  import des_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  v_in,
  input  logic  dec_in,
  input  half_t l_in,
  input  half_t r_in,
  input  cd_t   cd_in,
  output logic  v_out,
  output logic  dec_out,
  output blk_t  blk_out
);
  half_t l_fin;
  half_t r_fin;

  des_round u_round (
    .l_in (l_in),
    .r_in (r_in),
    .rkey (key_choice2(cd_in)),
    .l_out(l_fin),
    .r_out(r_fin)
  );

  always_ff @(posedge clk) begin
    if (rst)
      v_out <= 1'b0;
    else if (adv)
      v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      dec_out <= dec_in;
      blk_out <= exit_perm({r_fin, l_fin});
    end
  end
endmodule

// File: rtl/des_pipe.sv
module des_pipe
  import des_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_data,
  input  logic [63:0] in_key,
  input  logic        in_decrypt,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data,
  output logic        out_decrypt
);
  localparam int KEYED = ROUNDS - 1;

  logic  adv;
  logic  stg_v   [KEYED+1];
  logic  stg_dec [KEYED+1];
  half_t stg_l   [KEYED+1];
  half_t stg_r   [KEYED+1];
  cd_t   stg_cd  [KEYED+1];
  blk_t  ip_blk;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  assign ip_blk     = entry_perm(in_data);
  assign stg_v[0]   = in_valid;
  assign stg_dec[0] = in_decrypt;
  assign stg_l[0]   = ip_blk[BLK_W-1:HALF_W];
  assign stg_r[0]   = ip_blk[HALF_W-1:0];
  assign stg_cd[0]  = cd_rotate(key_choice1(in_key), rot_amount(1, in_decrypt), in_decrypt);

  for (genvar k = 1; k <= KEYED; k++) begin : g_stage
    des_stage #(.ROUND(k)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .adv    (adv),
      .v_in   (stg_v[k-1]),
      .dec_in (stg_dec[k-1]),
      .l_in   (stg_l[k-1]),
      .r_in   (stg_r[k-1]),
      .cd_in  (stg_cd[k-1]),
      .v_out  (stg_v[k]),
      .dec_out(stg_dec[k]),
      .l_out  (stg_l[k]),
      .r_out  (stg_r[k]),
      .cd_out (stg_cd[k])
    );
  end

  des_last_stage u_last (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .v_in   (stg_v[KEYED]),
    .dec_in (stg_dec[KEYED]),
    .l_in   (stg_l[KEYED]),
    .r_in   (stg_r[KEYED]),
    .cd_in  (stg_cd[KEYED]),
    .v_out  (out_valid),
    .dec_out(out_decrypt),
    .blk_out(out_data)
  );
endmodule

// File: rtl/des_pipe_checker.sv
module des_pipe_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        out_decrypt
);
  logic       rst_d;
  logic [5:0] occ;

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst)
      occ <= 6'd0;
    else
      occ <= occ + 6'(in_valid && in_ready) - 6'(out_valid && out_ready);
  end

  // R8: one edge after reset the output is empty
  always @(posedge clk) begin
    if (rst_d)
      p_reset_empty_r8: assert (!out_valid);
  end

  // R3 and R4: never more blocks in flight than stages
  p_occ_bound_r4: assert property (@(posedge clk) disable iff (rst)
    occ <= 6'd16);

  // R5: an output always has an accepted block behind it
  p_out_sourced_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> occ != 6'd0);

  // R6: a stalled result holds
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_decrypt)));

  // R7: input closed while output stalled
  p_stall_closes_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: input open while output empty
  p_empty_opens_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
endmodule

bind des_pipe des_pipe_checker u_des_pipe_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_decrypt(out_decrypt)
);

// File: tb/des_pipe_bench.sv
`timescale 1ns/1ps
module des_pipe_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [63:0] in_key = '0;
  logic        in_decrypt = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_decrypt;

  always #5 clk = ~clk;

  des_pipe u_des_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_key(in_key), .in_decrypt(in_decrypt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_decrypt(out_decrypt)
  );

  typedef struct {
    logic [63:0] data;
    logic        dec;
    int          acc;
    bit          lat;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          stall_mode = 1'b0;
  bit          saw_out = 1'b0;
  bit          held = 1'b0;
  logic [63:0] held_data;
  logic        held_dec;

  logic [63:0] vk [4] = '{64'h133457799BBCDFF1, 64'h0E329232EA6D0D73,
                          64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF};
  logic [63:0] vp [4] = '{64'h0123456789ABCDEF, 64'h8787878787878787,
                          64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF};
  logic [63:0] vc [4] = '{64'h85E813540F0AB405, 64'h0000000000000000,
                          64'h8CA64DE9C1B123A7, 64'h7359B2163E4EDC58};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] d, input logic [63:0] k, input logic dec,
                      input logic [63:0] exp, input bit keep, input string req);
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_key = k; in_decrypt = dec;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    it.data = exp; it.dec = dec; it.acc = cyc + 1; it.lat = !stall_mode; it.req = req;
    if (keep) sb_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while (sb_q.size() != 0 && guard < 2000) begin
      @(posedge clk);
      guard++;
    end
    check(sb_q.size() == 0, "R5 all expected blocks delivered", 64'(sb_q.size()), 64'd0);
  endtask

  // Monitor: picks out_ready, then compares what is transferred on the next edge.
  always @(negedge clk) begin
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    #1;
    if (!rst) begin
      if (held) begin
        check(out_valid, "R6 valid held under stall", 64'(out_valid), 64'd1);
        check(out_data == held_data && out_decrypt == held_dec,
              "R6 data held under stall", out_data, held_data);
      end
      held = 1'b0;
      if (out_valid && !out_ready) begin
        check(!in_ready, "R7 in_ready low while stalled", 64'(in_ready), 64'd0);
        held = 1'b1; held_data = out_data; held_dec = out_decrypt;
      end
      if (!out_valid)
        check(in_ready, "R7 in_ready high while empty", 64'(in_ready), 64'd1);
      if (out_valid) saw_out = 1'b1;
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R5/R8 output without accepted block", out_data, 64'd0);
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          check(out_data == it.data, it.req, out_data, it.data);
          check(out_decrypt == it.dec, "R10 mode follows block", 64'(out_decrypt), 64'(it.dec));
          if (it.lat)
            check(cyc - it.acc == 15, "R3 latency of 16 edges", 64'(cyc - it.acc), 64'd15);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R8 out_valid low after reset", 64'(out_valid), 64'd0);
    check(in_ready, "R7 in_ready high after reset", 64'(in_ready), 64'd1);

    // R1 single encrypt with latency, R2 single decrypt
    send(vp[0], vk[0], 1'b0, vc[0], 1'b1, "R1 encrypt vector 0");
    idle(20);
    send(vc[0], vk[0], 1'b1, vp[0], 1'b1, "R2 decrypt vector 0");
    idle(20);
    drain();

    // R4 back-to-back, key and mode switching on every block
    for (int i = 0; i < 4; i++) begin
      send(vp[i], vk[i], 1'b0, vc[i], 1'b1, "R4 back-to-back encrypt");
      send(vc[i], vk[i], 1'b1, vp[i], 1'b1, "R4 back-to-back decrypt");
    end
    for (int i = 3; i >= 0; i--)
      send(vc[i], vk[i], 1'b1, vp[i], 1'b1, "R2 decrypt reverse order");
    idle(2);
    drain();

    // R5 gaps between blocks
    for (int i = 0; i < 4; i++) begin
      send(vp[i], vk[i], 1'b0, vc[i], 1'b1, "R5 gapped encrypt");
      idle(i + 1);
    end
    drain();

    // R9 parity bits of the key ignored
    send(vp[0], vk[0] ^ 64'h0101010101010101, 1'b0, vc[0], 1'b1, "R9 parity flipped encrypt");
    send(vc[1], vk[1] ^ 64'h0101010101010101, 1'b1, vp[1], 1'b1, "R9 parity flipped decrypt");
    send(vp[2], 64'h0101010101010101, 1'b0, vc[2], 1'b1, "R9 parity-only key");
    idle(2);
    drain();

    // R6 R7 random back-pressure
    stall_mode = 1'b1;
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 4; i++)
        send((j % 2 == 0) ? vp[i] : vc[i], vk[i], 1'(j % 2),
             (j % 2 == 0) ? vc[i] : vp[i], 1'b1, "R6 result under back-pressure");
    idle(2);
    drain();
    stall_mode = 1'b0;
    idle(4);

    // R8 reset with blocks in flight
    for (int i = 0; i < 3; i++)
      send(vp[i], vk[i], 1'b0, vc[i], 1'b0, "R8 discarded");
    idle(4);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    saw_out = 1'b0;
    repeat (25) @(posedge clk);
    check(!saw_out, "R8 no stale block after reset", 64'(saw_out), 64'd0);
    send(vp[3], vk[3], 1'b0, vc[3], 1'b1, "R8 first block after reset");
    idle(2);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule